// File: doc/BRIEF.md
# Fractional Multiply-Accumulate ALU for an Audio Effects DSP

This unit is the arithmetic stage of a small audio effects processor. Each cycle in which `valid_i` is high it takes a 4-bit opcode and three signed 32-bit operands, A, X and Y, and computes one 32-bit result. The result appears one clock later on `r_o`, together with sign and zero flags. The operations cover three groups:

- Q31 fractional multiply-accumulate, in which the product X*Y is arithmetically shifted right by 31.
- Integer multiply-accumulate.
- A three-input add, a logical mix, signed compare-select operations, and linear interpolation between A and Y.

Most arithmetic opcodes come in two forms. One clamps to the 32-bit signed range. The other keeps only the low bits.

A separate 64-bit accumulator collects fractional products. It is driven by a dedicated opcode that also passes A straight to the result, and it is visible on `acc_o`. Opcodes with no arithmetic defined here (0xC, 0xD, 0xF) pass A through and raise an unsupported flag, so the surrounding sequencer can trap them. The register file, program store and instruction sequencing all sit outside this block.

Top module: `fx_mac_alu`

## Requirements
- R1: While `rst_ni` is low the outputs are as follows: `r_o`=0, `acc_o`=0, `valid_o`=0, `sat_o`=0, `unsup_o`=0, `neg_o`=0, `zero_o`=1.
- R2: Opcode 0x0 gives sat(A + (X*Y >>> 31)) and opcode 0x1 gives sat(A - (X*Y >>> 31)). The product is taken at full width, so 0x80000000 * 0x80000000 yields +2^31 before the add.
- R3: Opcodes 0x2 and 0x3 compute the same values as 0x0 and 0x1 but return the low 32 bits of the exact sum without clamping.
- R4: Opcode 0x4 gives sat(A + X*Y) with an integer product. Opcode 0x5 takes the exact A + X*Y, keeps its low 31 bits, and sign-extends bit 30 into bit 31.
- R5: Opcode 0x6 gives sat(A + X + Y).
- R6: Opcode 0x7 returns A and adds the sign-extended (X*Y >>> 31) into the 64-bit accumulator. No other opcode, and no idle cycle, changes `acc_o`.
- R7: Opcode 0x8 returns (A AND X) XOR Y.
- R8: All comparisons are signed. Opcode 0x9 returns X if A >= Y and NOT X otherwise. Opcode 0xA returns X if A >= Y and Y otherwise. Opcode 0xB returns X if A < Y and Y otherwise.
- R9: Opcode 0xE gives sat(A + ((X * (Y - A)) >>> 31)), with Y - A formed without overflow.
- R10: sat(v) is 0x7FFFFFFF for v > 2^31-1, 0x80000000 for v < -2^31, and v otherwise. `sat_o` is high for exactly the one cycle in which a clamped result is presented, and at no other time.
- R11: Opcodes 0xC, 0xD and 0xF return A and raise `unsup_o` for the cycle in which that result is presented.
- R12: A result appears on `r_o`, with `valid_o` high, on the clock edge after `valid_i` was high. While `valid_i` is low, `r_o` holds its value and `valid_o`, `sat_o` and `unsup_o` are low.
- R13: `neg_o` equals bit 31 of `r_o`, and `zero_o` is high exactly when `r_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation request this cycle |
| op_i | input | 4 | Opcode |
| a_i | input | 32 | Operand A, signed |
| x_i | input | 32 | Operand X, signed |
| y_i | input | 32 | Operand Y, signed |
| r_o | output | 32 | Registered result |
| valid_o | output | 1 | Result presented this cycle |
| sat_o | output | 1 | Presented result was clamped |
| unsup_o | output | 1 | Presented opcode is not implemented |
| neg_o | output | 1 | Result is negative |
| zero_o | output | 1 | Result is zero |
| acc_o | output | 64 | Accumulator value |

## Verification
The properties assume that `op_i` and the operands carry known values whenever `valid_i` is high. They also assume that inputs change only between clock edges, so that `$past` of the operands is the value the unit actually computed with.

The stimulus meets both assumptions. It drives every input on the falling edge and keeps all inputs at defined values throughout, including idle cycles. Operands are drawn with a bias toward 0x7FFFFFFF, 0x80000000, 0 and -1, so that both clamp boundaries and the full-width fractional corner are reached often.

// File: rtl/fxalu_pkg.sv
package fxalu_pkg;
  typedef enum logic [3:0] {
    OP_FMAC    = 4'h0,
    OP_FMSC    = 4'h1,
    OP_FMAC_W  = 4'h2,
    OP_FMSC_W  = 4'h3,
    OP_IMAC    = 4'h4,
    OP_IMAC_W  = 4'h5,
    OP_ADD3    = 4'h6,
    OP_ACCUM   = 4'h7,
    OP_ANDXOR  = 4'h8,
    OP_TSTNEG  = 4'h9,
    OP_SEL_GE  = 4'hA,
    OP_SEL_LT  = 4'hB,
    OP_RSVD_C  = 4'hC,
    OP_RSVD_D  = 4'hD,
    OP_LERP    = 4'hE,
    OP_RSVD_F  = 4'hF
  } alu_op_e;
endpackage

// File: rtl/fxalu_mul.sv
module fxalu_mul #(
  parameter int AW = 32,
  parameter int BW = 33,
  localparam int PW = AW + BW
) (
  input  logic signed [AW-1:0] a_i,
  input  logic signed [BW-1:0] b_i,
  output logic signed [PW-1:0] p_o
);
  logic signed [PW-1:0] a_ext, b_ext;
  assign a_ext = PW'(a_i);
  assign b_ext = PW'(b_i);
  assign p_o   = a_ext * b_ext;
endmodule

// File: rtl/fxalu_sat.sv
module fxalu_sat #(
  parameter int IW = 66,
  parameter int OW = 32
) (
  input  logic [IW-1:0] v_i,
  output logic [OW-1:0] q_o,
  output logic          hit_o
);
  // in range iff all bits from OW-1 up match the sign
  logic [IW-OW:0] top;
  assign top   = v_i[IW-1:OW-1];
  assign hit_o = ~(&top) & (|top);
  always_comb begin
    if (!hit_o)         q_o = v_i[OW-1:0];
    else if (v_i[IW-1]) q_o = {1'b1, {(OW-1){1'b0}}};
    else                q_o = {1'b0, {(OW-1){1'b1}}};
  end
endmodule

// File: rtl/fxalu_acc.sv
module fxalu_acc #(
  parameter int AW = 64,
  parameter int FW = 34
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic signed [FW-1:0] inc_i,
  output logic        [AW-1:0] acc_o
);
  logic signed [AW-1:0] acc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= acc_q + AW'(inc_i);
  end
  assign acc_o = acc_q;
endmodule

// File: rtl/fx_mac_alu.sv
module fx_mac_alu
  import fxalu_pkg::*;
#(
  parameter int DW    = 32,
  parameter int ACC_W = 2 * DW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [3:0]       op_i,
  input  logic [DW-1:0]    a_i,
  input  logic [DW-1:0]    x_i,
  input  logic [DW-1:0]    y_i,
  output logic [DW-1:0]    r_o,
  output logic             valid_o,
  output logic             sat_o,
  output logic             unsup_o,
  output logic             neg_o,
  output logic             zero_o,
  output logic [ACC_W-1:0] acc_o
);
  localparam int BW = DW + 1;      // room for Y - A
  localparam int PW = DW + BW;
  localparam int WW = PW + 1;      // wide sum width
  localparam int FW = DW + 2;      // fractional term width
  localparam int SH = DW - 1;

  alu_op_e op;
  assign op = alu_op_e'(op_i);

  logic signed [DW-1:0] a_s, x_s, y_s;
  assign a_s = a_i;
  assign x_s = x_i;
  assign y_s = y_i;

  logic signed [BW-1:0] mul_b;
  logic signed [PW-1:0] prod, frac;
  assign mul_b = (op == OP_LERP) ? (BW'(y_s) - BW'(a_s)) : BW'(y_s);

  fxalu_mul #(.AW(DW), .BW(BW)) u_mul (
    .a_i(x_s), .b_i(mul_b), .p_o(prod)
  );

  assign frac = prod >>> SH;

  logic signed [WW-1:0] a_w, x_w, y_w, p_w, f_w, wide;
  assign a_w = WW'(a_s);
  assign x_w = WW'(x_s);
  assign y_w = WW'(y_s);
  assign p_w = WW'(prod);
  assign f_w = WW'(frac);

  logic [DW-1:0] alu_res, sat_res, nxt_res;
  logic          do_sat, sat_hit, unsup, acc_en, a_ge_y;
  assign a_ge_y = a_s >= y_s;

  always_comb begin
    wide    = '0;
    alu_res = a_i;
    do_sat  = 1'b0;
    unsup   = 1'b0;
    acc_en  = 1'b0;
    unique case (op)
      OP_FMAC:   begin wide = a_w + f_w; do_sat = 1'b1; end
      OP_FMSC:   begin wide = a_w - f_w; do_sat = 1'b1; end
      OP_FMAC_W: begin wide = a_w + f_w; alu_res = wide[DW-1:0]; end
      OP_FMSC_W: begin wide = a_w - f_w; alu_res = wide[DW-1:0]; end
      OP_IMAC:   begin wide = a_w + p_w; do_sat = 1'b1; end
      OP_IMAC_W: begin
        wide    = a_w + p_w;
        alu_res = {wide[DW-2], wide[DW-2:0]};
      end
      OP_ADD3:   begin wide = a_w + x_w + y_w; do_sat = 1'b1; end
      OP_ACCUM:  acc_en = 1'b1;
      OP_ANDXOR: alu_res = (a_i & x_i) ^ y_i;
      OP_TSTNEG: alu_res = a_ge_y ? x_i : ~x_i;
      OP_SEL_GE: alu_res = a_ge_y ? x_i : y_i;
      OP_SEL_LT: alu_res = a_ge_y ? y_i : x_i;
      OP_LERP:   begin wide = a_w + f_w; do_sat = 1'b1; end
      default:   unsup = 1'b1;
    endcase
  end

  fxalu_sat #(.IW(WW), .OW(DW)) u_sat (
    .v_i(wide), .q_o(sat_res), .hit_o(sat_hit)
  );

  always_comb nxt_res = do_sat ? sat_res : alu_res;

  fxalu_acc #(.AW(ACC_W), .FW(FW)) u_acc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (valid_i & acc_en),
    .inc_i (frac[FW-1:0]),
    .acc_o (acc_o)
  );

  logic [DW-1:0] r_q;
  logic          valid_q, sat_q, unsup_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_q     <= '0;
      valid_q <= 1'b0;
      sat_q   <= 1'b0;
      unsup_q <= 1'b0;
    end else begin
      valid_q <= valid_i;
      sat_q   <= valid_i & do_sat & sat_hit;
      unsup_q <= valid_i & unsup;
      if (valid_i) r_q <= nxt_res;
    end
  end

  assign r_o     = r_q;
  assign valid_o = valid_q;
  assign sat_o   = sat_q;
  assign unsup_o = unsup_q;
  assign neg_o   = r_q[DW-1];
  assign zero_o  = (r_q == '0);
endmodule

// File: rtl/fx_mac_alu_chk.sv
module fx_mac_alu_chk #(
  parameter int DW    = 32,
  parameter int ACC_W = 2 * DW
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [3:0]       op_i,
  input logic [DW-1:0]    a_i,
  input logic [DW-1:0]    r_o,
  input logic             valid_o,
  input logic             sat_o,
  input logic             unsup_o,
  input logic [ACC_W-1:0] acc_o
);
  localparam logic [DW-1:0] POS_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] NEG_MAX = {1'b1, {(DW-1){1'b0}}};

  logic rsvd_op, acc_op;
  assign rsvd_op = (op_i == 4'hC) || (op_i == 4'hD) || (op_i == 4'hF);
  assign acc_op  = valid_i && (op_i == 4'h7);

  assert_sat_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_o |-> (r_o == POS_MAX || r_o == NEG_MAX));

  assert_sat_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !sat_o);

  assert_unsup_pass_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && rsvd_op) |=> (unsup_o && r_o == $past(a_i)));

  assert_acc_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_op |=> $stable(acc_o));

  assert_acc_pass_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_op |=> (r_o == $past(a_i)));

  assert_idle_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(r_o) && !unsup_o && !valid_o));

  assert_latency_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
endmodule

bind fx_mac_alu fx_mac_alu_chk #(.DW(DW), .ACC_W(ACC_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .op_i   (op_i),
  .a_i    (a_i),
  .r_o    (r_o),
  .valid_o(valid_o),
  .sat_o  (sat_o),
  .unsup_o(unsup_o),
  .acc_o  (acc_o)
);

// File: tb/fx_mac_alu_test.sv
`timescale 1ns/1ps
module fx_mac_alu_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] a_i = '0, x_i = '0, y_i = '0;
  logic [31:0] r_o;
  logic        valid_o, sat_o, unsup_o, neg_o, zero_o;
  logic [63:0] acc_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic signed [63:0] acc_m = '0;
  logic [31:0] r_hold = '0;

  localparam logic signed [95:0] MAXV = 96'sh7FFF_FFFF;
  localparam logic signed [95:0] MINV = -96'sh8000_0000;

  always #2 clk = ~clk;

  fx_mac_alu uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .a_i(a_i), .x_i(x_i), .y_i(y_i), .r_o(r_o), .valid_o(valid_o),
    .sat_o(sat_o), .unsup_o(unsup_o), .neg_o(neg_o), .zero_o(zero_o),
    .acc_o(acc_o)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic signed [95:0] sx(input logic [31:0] v);
    logic signed [31:0] s;
    s = v;
    return 96'(s);
  endfunction

  function automatic logic [31:0] clamp(input logic signed [95:0] v, inout logic s);
    if (v > MAXV) begin s = 1'b1; return 32'h7FFF_FFFF; end
    if (v < MINV) begin s = 1'b1; return 32'h8000_0000; end
    return v[31:0];
  endfunction

  task automatic model(input logic [3:0] op, input logic [31:0] a, x, y,
                       output logic [31:0] r, output logic s, output logic u,
                       output logic signed [95:0] inc, output logic ai);
    logic signed [95:0] va, vx, vy, pr, fr, t;
    va = sx(a); vx = sx(x); vy = sx(y);
    pr = vx * vy;
    fr = pr >>> 31;
    s = 1'b0; u = 1'b0; ai = 1'b0; inc = fr; r = a;
    case (op)
      4'h0: r = clamp(va + fr, s);
      4'h1: r = clamp(va - fr, s);
      4'h2: begin t = va + fr; r = t[31:0]; end
      4'h3: begin t = va - fr; r = t[31:0]; end
      4'h4: r = clamp(va + pr, s);
      4'h5: begin t = va + pr; r = {t[30], t[30:0]}; end
      4'h6: r = clamp(va + vx + vy, s);
      4'h7: ai = 1'b1;
      4'h8: r = (a & x) ^ y;
      4'h9: r = (va >= vy) ? x : ~x;
      4'hA: r = (va >= vy) ? x : y;
      4'hB: r = (va < vy) ? x : y;
      4'hE: begin t = (vx * (vy - va)) >>> 31; r = clamp(va + t, s); end
      default: u = 1'b1;
    endcase
  endtask

  task automatic do_op(input logic [3:0] op, input logic [31:0] a, x, y,
                       input string tag);
    logic [31:0] r_e;
    logic s_e, u_e, ai;
    logic signed [95:0] inc;
    model(op, a, x, y, r_e, s_e, u_e, inc, ai);
    valid_i = 1'b1; op_i = op; a_i = a; x_i = x; y_i = y;
    if (ai) acc_m = acc_m + inc[63:0];
    @(negedge clk);
    chk(tag, "r_o", 64'(r_o), 64'(r_e));
    chk("R10", "sat_o", 64'(sat_o), 64'(s_e));
    chk("R11", "unsup_o", 64'(unsup_o), 64'(u_e));
    chk("R12", "valid_o", 64'(valid_o), 64'd1);
    chk("R13", "neg_o", 64'(neg_o), 64'(r_e[31]));
    chk("R13", "zero_o", 64'(zero_o), 64'(r_e == 32'd0));
    chk("R6", "acc_o", acc_o, acc_m);
    r_hold = r_e;
  endtask

  task automatic idle(input logic [3:0] op);
    valid_i = 1'b0; op_i = op; a_i = 32'h1234_5678; x_i = 32'h8000_0000; y_i = 32'h8000_0000;
    @(negedge clk);
    chk("R12", "r_o hold", 64'(r_o), 64'(r_hold));
    chk("R12", "valid_o idle", 64'(valid_o), 64'd0);
    chk("R10", "sat_o idle", 64'(sat_o), 64'd0);
    chk("R11", "unsup_o idle", 64'(unsup_o), 64'd0);
    chk("R6", "acc_o idle", acc_o, acc_m);
  endtask

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 5))
      0: return 32'h7FFF_FFFF;
      1: return 32'h8000_0000;
      2: return 32'h0;
      3: return 32'hFFFF_FFFF;
      default: return $urandom();
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "r_o", 64'(r_o), 64'd0);
    chk("R1", "acc_o", acc_o, 64'd0);
    chk("R1", "valid_o", 64'(valid_o), 64'd0);
    chk("R1", "sat_o", 64'(sat_o), 64'd0);
    chk("R1", "unsup_o", 64'(unsup_o), 64'd0);
    chk("R1", "zero_o", 64'(zero_o), 64'd1);
    rst_ni = 1'b1;
    @(negedge clk);

    do_op(4'h0, 32'h1000_0000, 32'h4000_0000, 32'h4000_0000, "R2");
    do_op(4'h0, 32'h0, 32'h8000_0000, 32'h8000_0000, "R2");
    do_op(4'h0, 32'h7FFF_FFFF, 32'h4000_0000, 32'h4000_0000, "R2");
    do_op(4'h1, 32'h8000_0000, 32'h4000_0000, 32'h4000_0000, "R2");
    do_op(4'h1, 32'h0, 32'h8000_0000, 32'h8000_0000, "R2");
    do_op(4'h2, 32'h7FFF_FFFF, 32'h4000_0000, 32'h4000_0000, "R3");
    do_op(4'h3, 32'h8000_0000, 32'h4000_0000, 32'h4000_0000, "R3");
    do_op(4'h2, 32'h0, 32'h8000_0000, 32'h8000_0000, "R3");
    do_op(4'h4, 32'd5, 32'd3, 32'hFFFF_FFF9, "R4");
    do_op(4'h4, 32'h0, 32'h0001_0000, 32'h0001_0000, "R4");
    do_op(4'h4, 32'h0, 32'h8000_0000, 32'h0000_0002, "R4");
    do_op(4'h5, 32'h0, 32'h0001_0000, 32'h0000_8000, "R4");
    do_op(4'h5, 32'h3FFF_FFFF, 32'd1, 32'd1, "R4");
    do_op(4'h6, 32'h8000_0000, 32'h8000_0000, 32'h8000_0000, "R5");
    do_op(4'h6, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h0, "R5");
    do_op(4'h6, 32'd10, 32'hFFFF_FFF6, 32'd0, "R5");
    do_op(4'h7, 32'hCAFE_0001, 32'h4000_0000, 32'h4000_0000, "R6");
    do_op(4'h7, 32'h0, 32'h8000_0000, 32'h8000_0000, "R6");
    do_op(4'h7, 32'h0, 32'h8000_0000, 32'h4000_0000, "R6");
    do_op(4'h8, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'h0F0F_0000, "R7");
    do_op(4'h9, 32'hFFFF_FFFF, 32'h1234_5678, 32'd1, "R8");
    do_op(4'h9, 32'd1, 32'h1234_5678, 32'hFFFF_FFFF, "R8");
    do_op(4'hA, 32'd7, 32'hAAAA_0000, 32'd7, "R8");
    do_op(4'hA, 32'h8000_0000, 32'hAAAA_0000, 32'd0, "R8");
    do_op(4'hB, 32'd7, 32'hAAAA_0000, 32'd7, "R8");
    do_op(4'hB, 32'h8000_0000, 32'hAAAA_0000, 32'd0, "R8");
    do_op(4'hE, 32'h0, 32'h4000_0000, 32'h4000_0000, "R9");
    do_op(4'hE, 32'h8000_0000, 32'h8000_0000, 32'h7FFF_FFFF, "R9");
    do_op(4'hE, 32'h2000_0000, 32'h7FFF_FFFF, 32'h6000_0000, "R9");
    do_op(4'hC, 32'h1111_2222, 32'h0, 32'h0, "R11");
    do_op(4'hD, 32'h0, 32'h0, 32'h0, "R11");
    do_op(4'hF, 32'h8765_4321, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R11");
    idle(4'h7);
    idle(4'h0);
    do_op(4'h0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R10");
    do_op(4'h8, 32'h0, 32'h0, 32'h0, "R10");
    idle(4'hC);

    for (int i = 0; i < 400; i++) begin
      logic [3:0] op;
      op = 4'($urandom_range(0, 15));
      do_op(op, pick(), pick(), pick(), "R12");
      if ((i % 37) == 0) idle(op);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule